// File: doc/BRIEF.md
# Register Burst Address Sequencer

This block is the register pointer of a small sensor register file that is reached over a serial bus. When a transaction opens, it loads the start address and raises a valid flag. After each transferred byte it moves to the address the next byte will use. The next address is not always the current one plus one. In fast mode the high byte of every sample pair is skipped. A configuration bit can drop the temperature register from bursts. Inside the sample buffer window the pointer loops back, so a long burst keeps reading the X/Y/Z data.

The mode bits are captured when the transaction opens and held for the whole burst. A single-byte access always reaches the address it names, including one that auto-increment would skip. Reads and writes use the same sequence, so the block has no direction input. The serial protocol, the register storage and the data source are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the address is 00h with valid low. A cycle with `txn_start` high loads `start_addr` into the address on the next clock and raises valid, whatever the address is, including 01h and the high-byte registers.
- R2: With valid high and neither `byte_done`, `txn_start` nor `txn_end` asserted, the address and valid hold. A `byte_done` while valid is low leaves the address unchanged.
- R3: `txn_end` drops valid on the next clock. `txn_start` takes priority over `txn_end` and `byte_done` in the same cycle.
- R4: In normal mode (fast bit 0), the live sample region 02h–09h and the plain addresses around it advance by one per byte, visiting both the even low bytes and the odd high bytes (09h goes to 0Ah, and 0Ah goes to 0Bh).
- R5: In normal mode the buffer status at 0Bh goes to 0Ch. Inside the buffer window 0Ch–11h the pointer advances by one, and 11h goes back to 0Ch. A 13-byte burst from 0Bh therefore yields 0Bh, 0Ch..11h, 0Ch..11h.
- R6: In fast mode (fast bit 1), a step from any address in the live region goes to the next even address above it. Pairs are aligned so that the low byte is even, so 02h goes to 04h, 03h to 04h and 08h to 0Ah. Plain addresses still advance by one.
- R7: In fast mode the buffer window is walked as 0Ch, 0Eh, 10h and back to 0Ch. A step from 10h or 11h goes to 0Ch.
- R8: When the temperature-include bit is 0, a step from 00h goes to 02h. When it is 1, a step from 00h goes to 01h. This holds in both modes.
- R9: Above the buffer window the pointer advances by one, and the last implemented address (3Fh) goes to 00h.
- R10: The fast and temperature-include bits are captured when `txn_start` is high. Changes to them during a burst do not alter its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Transaction opens; load `start_addr` |
| start_addr | input | 8 | First register address of the transaction |
| fast_mode_in | input | 1 | 1 = skip high-byte registers of sample pairs |
| temp_inc_in | input | 1 | 1 = temperature register included in bursts |
| byte_done | input | 1 | One byte has been transferred; advance |
| txn_end | input | 1 | Transaction closed (chip-select release) |
| addr_o | output | 8 | Current register address |
| addr_valid_o | output | 1 | A transaction is open and `addr_o` is in use |

## Verification
A wrong region decode or a wrong step shows on `addr_o` one clock after the `byte_done` that used it. It shows as a wrong address or as an odd address in fast mode, so each table vector opens one burst and checks that single step. Wrong mode capture stays hidden until a step reaches a point where the mode matters. For that reason the mid-burst mode-change test walks through 00h, 01h and 02h. A long burst is needed to expose a broken wrap, because that fault only appears when the pointer reaches the top of the buffer window.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [1:0] {
        RG_PLAIN = 2'd0,
        RG_LIVE  = 2'd1,
        RG_BUF   = 2'd2,
        RG_TOP   = 2'd3
    } region_e;

    typedef struct packed {
        logic fast;
        logic temp_inc;
    } mode_t;

endpackage

// File: rtl/bsq_region_decode.sv
module bsq_region_decode
    import bsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LIVE_FIRST = 8'h02,
    parameter logic [ADDR_W-1:0] LIVE_LAST  = 8'h09,
    parameter logic [ADDR_W-1:0] BUF_FIRST  = 8'h0C,
    parameter logic [ADDR_W-1:0] BUF_LAST   = 8'h11,
    parameter logic [ADDR_W-1:0] LAST_ADDR  = 8'h3F
) (
    input  logic [ADDR_W-1:0] cur,
    output region_e           region
);

    logic in_live;
    logic in_buf;

    assign in_live = (cur >= LIVE_FIRST) && (cur <= LIVE_LAST);
    assign in_buf  = (cur >= BUF_FIRST) && (cur <= BUF_LAST);

    always_comb begin
        if (cur == LAST_ADDR) begin
            region = RG_TOP;
        end else if (in_buf) begin
            region = RG_BUF;
        end else if (in_live) begin
            region = RG_LIVE;
        end else begin
            region = RG_PLAIN;
        end
    end

endmodule

// File: rtl/bsq_step_calc.sv
module bsq_step_calc
    import bsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] TEMP_ADDR = 8'h01,
    parameter logic [ADDR_W-1:0] BUF_FIRST = 8'h0C,
    parameter logic [ADDR_W-1:0] BUF_LAST  = 8'h11
) (
    input  logic [ADDR_W-1:0] cur,
    input  region_e           region,
    input  mode_t             mode,
    output logic [ADDR_W-1:0] nxt
);

    localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TEMP_SKIP = TEMP_ADDR + ONE;

    logic [ADDR_W-1:0] plain_next;
    logic [ADDR_W-1:0] pair_next;

    // next address by one; next even address (pair low byte) above cur
    assign plain_next = cur + ONE;
    assign pair_next  = {cur[ADDR_W-1:1], 1'b1} + ONE;

    always_comb begin
        nxt = plain_next;
        unique case (region)
            RG_TOP: begin
                nxt = '0;
            end
            RG_BUF: begin
                if (mode.fast) begin
                    nxt = (pair_next > BUF_LAST) ? BUF_FIRST : pair_next;
                end else begin
                    nxt = (cur == BUF_LAST) ? BUF_FIRST : plain_next;
                end
            end
            RG_LIVE: begin
                nxt = mode.fast ? pair_next : plain_next;
            end
            default: begin
                if ((plain_next == TEMP_ADDR) && !mode.temp_inc) begin
                    nxt = TEMP_SKIP;
                end else begin
                    nxt = plain_next;
                end
            end
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] TEMP_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] LIVE_FIRST = 8'h02,
    parameter logic [ADDR_W-1:0] LIVE_LAST  = 8'h09,
    parameter logic [ADDR_W-1:0] BUF_FIRST  = 8'h0C,
    parameter logic [ADDR_W-1:0] BUF_LAST   = 8'h11,
    parameter logic [ADDR_W-1:0] LAST_ADDR  = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              fast_mode_in,
    input  logic              temp_inc_in,
    input  logic              byte_done,
    input  logic              txn_end,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        mode_t             mode;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    region_e           region;
    logic [ADDR_W-1:0] step_addr;

    bsq_region_decode #(
        .ADDR_W     (ADDR_W),
        .LIVE_FIRST (LIVE_FIRST),
        .LIVE_LAST  (LIVE_LAST),
        .BUF_FIRST  (BUF_FIRST),
        .BUF_LAST   (BUF_LAST),
        .LAST_ADDR  (LAST_ADDR)
    ) u_region (
        .cur    (st_q.addr),
        .region (region)
    );

    bsq_step_calc #(
        .ADDR_W    (ADDR_W),
        .TEMP_ADDR (TEMP_ADDR),
        .BUF_FIRST (BUF_FIRST),
        .BUF_LAST  (BUF_LAST)
    ) u_step (
        .cur    (st_q.addr),
        .region (region),
        .mode   (st_q.mode),
        .nxt    (step_addr)
    );

    always_comb begin
        st_d = st_q;
        if (txn_start) begin
            st_d.addr          = start_addr;
            st_d.valid         = 1'b1;
            st_d.mode.fast     = fast_mode_in;
            st_d.mode.temp_inc = temp_inc_in;
        end else if (txn_end) begin
            st_d.valid = 1'b0;
        end else if (byte_done && st_q.valid) begin
            st_d.addr = step_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o       = st_q.addr;
    assign addr_valid_o = st_q.valid;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] TEMP_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] LIVE_FIRST = 8'h02,
    parameter logic [ADDR_W-1:0] LIVE_LAST  = 8'h09,
    parameter logic [ADDR_W-1:0] BUF_FIRST  = 8'h0C,
    parameter logic [ADDR_W-1:0] BUF_LAST   = 8'h11,
    parameter logic [ADDR_W-1:0] LAST_ADDR  = 8'h3F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              fast_mode_in,
    input logic              temp_inc_in,
    input logic              byte_done,
    input logic              txn_end,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_valid_o
);

    logic chk_fast;
    logic chk_tinc;
    logic adv;
    logic in_win;
    logic pair_area;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_fast <= 1'b0;
            chk_tinc <= 1'b0;
        end else if (txn_start) begin
            chk_fast <= fast_mode_in;
            chk_tinc <= temp_inc_in;
        end
    end

    assign adv       = addr_valid_o && byte_done && !txn_start && !txn_end;
    assign in_win    = (addr_o >= BUF_FIRST) && (addr_o <= BUF_LAST);
    assign pair_area = in_win || ((addr_o >= LIVE_FIRST) && (addr_o <= LIVE_LAST));

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> (addr_o == $past(start_addr)) && addr_valid_o); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_start && !txn_end && !byte_done) |=> $stable(addr_o) && $stable(addr_valid_o)); // R2

    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_end && !txn_start) |=> !addr_valid_o); // R3

    AST_WINDOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && in_win) |=> (addr_o >= BUF_FIRST) && (addr_o <= BUF_LAST)); // R5

    AST_FAST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && chk_fast && pair_area) |=> !addr_o[0]); // R6

    AST_TEMP_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !chk_tinc) |=> addr_o != TEMP_ADDR); // R8

    AST_MAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && addr_o <= LAST_ADDR) |=> addr_o <= LAST_ADDR); // R9

endmodule

bind burst_addr_seq bsq_checker #(
    .ADDR_W     (ADDR_W),
    .TEMP_ADDR  (TEMP_ADDR),
    .LIVE_FIRST (LIVE_FIRST),
    .LIVE_LAST  (LIVE_LAST),
    .BUF_FIRST  (BUF_FIRST),
    .BUF_LAST   (BUF_LAST),
    .LAST_ADDR  (LAST_ADDR)
) u_bsq_chk (.*);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       txn_start;
    logic [7:0] start_addr;
    logic       fast_mode_in;
    logic       temp_inc_in;
    logic       byte_done;
    logic       txn_end;
    logic [7:0] addr_o;
    logic       addr_valid_o;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_start    (txn_start),
        .start_addr   (start_addr),
        .fast_mode_in (fast_mode_in),
        .temp_inc_in  (temp_inc_in),
        .byte_done    (byte_done),
        .txn_end      (txn_end),
        .addr_o       (addr_o),
        .addr_valid_o (addr_valid_o)
    );

    typedef struct packed {
        logic [7:0] first;
        logic       fast;
        logic       tinc;
        logic [7:0] next;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{8'h00, 1'b0, 1'b1, 8'h01},  // R8 temp included
        '{8'h00, 1'b0, 1'b0, 8'h02},  // R8 temp skipped
        '{8'h00, 1'b1, 1'b0, 8'h02},  // R8 fast, skipped
        '{8'h01, 1'b0, 1'b0, 8'h02},  // R1 direct access to skipped reg
        '{8'h02, 1'b0, 1'b1, 8'h03},  // R4
        '{8'h03, 1'b0, 1'b1, 8'h04},  // R4
        '{8'h09, 1'b0, 1'b1, 8'h0A},  // R4
        '{8'h0A, 1'b0, 1'b1, 8'h0B},  // R4
        '{8'h0B, 1'b0, 1'b1, 8'h0C},  // R5
        '{8'h11, 1'b0, 1'b1, 8'h0C},  // R5
        '{8'h0F, 1'b0, 1'b1, 8'h10},  // R5
        '{8'h02, 1'b1, 1'b1, 8'h04},  // R6
        '{8'h03, 1'b1, 1'b1, 8'h04},  // R6
        '{8'h08, 1'b1, 1'b1, 8'h0A},  // R6
        '{8'h0A, 1'b1, 1'b1, 8'h0B},  // R6 plain still +1
        '{8'h0B, 1'b1, 1'b1, 8'h0C},  // R7
        '{8'h0C, 1'b1, 1'b1, 8'h0E},  // R7
        '{8'h10, 1'b1, 1'b1, 8'h0C},  // R7
        '{8'h11, 1'b1, 1'b1, 8'h0C},  // R7
        '{8'h12, 1'b0, 1'b1, 8'h13},  // R9
        '{8'h3F, 1'b0, 1'b1, 8'h00},  // R9
        '{8'h3F, 1'b1, 1'b0, 8'h00}   // R9
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic open_burst(input logic [7:0] a, input logic f, input logic t);
        txn_start    = 1'b1;
        start_addr   = a;
        fast_mode_in = f;
        temp_inc_in  = t;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic pulse_byte();
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic close_burst();
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; txn_start = 1'b0; start_addr = 8'h00;
        fast_mode_in = 1'b0; temp_inc_in = 1'b1; byte_done = 1'b0; txn_end = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset addr", addr_o, 8'h00);
        check("R1 reset valid", {7'd0, addr_valid_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // single-step vector table
        for (int i = 0; i < NVEC; i++) begin
            open_burst(VEC[i].first, VEC[i].fast, VEC[i].tinc);
            check($sformatf("R1 vec%0d load", i), addr_o, VEC[i].first);
            pulse_byte();
            check($sformatf("vec%0d step (R4-R9 table)", i), addr_o, VEC[i].next);
            close_burst();
        end

        // R5: 13-byte normal burst from buffer status
        open_burst(8'h0B, 1'b0, 1'b1);
        check("R5 burst byte 0", addr_o, 8'h0B);
        for (int i = 1; i < 13; i++) begin
            pulse_byte();
            check($sformatf("R5 burst byte %0d", i), addr_o, 8'h0C + 8'((i - 1) % 6));
        end
        close_burst();

        // R7: fast buffer loop
        open_burst(8'h0C, 1'b1, 1'b1);
        for (int i = 1; i < 8; i++) begin
            pulse_byte();
            check($sformatf("R7 fast loop %0d", i), addr_o, 8'h0C + 8'(2 * (i % 3)));
        end

        // R2: hold without strobe
        repeat (3) @(negedge clk);
        check("R2 hold addr", addr_o, 8'h0E);
        check("R2 hold valid", {7'd0, addr_valid_o}, 8'h01);

        // R3: end closes, strobes then ignored
        close_burst();
        check("R3 end valid", {7'd0, addr_valid_o}, 8'h00);
        pulse_byte();
        check("R2 strobe while idle", addr_o, 8'h0E);

        // R3: start wins over end and strobe
        txn_end = 1'b1; byte_done = 1'b1;
        open_burst(8'h05, 1'b0, 1'b1);
        txn_end = 1'b0; byte_done = 1'b0;
        check("R3 start priority addr", addr_o, 8'h05);
        check("R3 start priority valid", {7'd0, addr_valid_o}, 8'h01);
        close_burst();

        // R10: mode change mid-burst ignored
        open_burst(8'h00, 1'b0, 1'b1);
        fast_mode_in = 1'b1; temp_inc_in = 1'b0;
        pulse_byte();
        check("R10 temp kept", addr_o, 8'h01);
        pulse_byte();
        pulse_byte();
        check("R10 fast not taken", addr_o, 8'h03);
        close_burst();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule